// File: doc/BRIEF.md
# Warp Lane Activity Stack

This block decides, for a warp of threads that share one instruction stream, which lanes may commit results while the warp runs nested conditional code. It holds one activity bit per lane and drives the current activity mask to the processing elements. The issue logic sends it a command for each conditional construct: open a conditional with a per-lane condition vector, switch to the alternative path, or close the construct. With these commands the block narrows, flips and restores the mask.

When every currently active lane agrees on a condition, the block pushes nothing. It reports the branch as uniform and gives its direction, so the front end can skip the path no lane will run. The front end must then leave out the matching alternative and close commands for that construct. A divergent conditional saves the enclosing mask and the condition vector on an internal stack. Because of this, the alternative path is computed from saved state, and closing the construct brings the enclosing mask back exactly. Two sticky flags record a divergent open with the stack full and an alternative or close issued at top level.

Top module: `simt_mask_stack`

## Requirements
- R1: While reset is held and on the first cycle after it, `active_mask` is all ones and `branch_uniform`, `uniform_taken`, `overflow` and `underflow` are 0.
- R2: An open command (`op` = 2'b01) with `active_mask & cond` equal to zero or equal to `active_mask` is uniform. It leaves the mask and stack unchanged. On the next cycle `branch_uniform` is 1 and `uniform_taken` is 1 exactly when that AND is nonzero. This also applies when the stack is full.
- R3: Any other open command pushes. On the next cycle `active_mask` equals the previous mask ANDed with `cond`, and `branch_uniform` is 0.
- R4: An alternative command (`op` = 2'b10) below top level sets `active_mask` to the enclosing mask ANDed with the inverse of the condition given at the matching open. Its own `cond` input is ignored.
- R5: A close command (`op` = 2'b11) below top level pops one level and restores the mask that was current before the matching open.
- R6: Nested constructs unwind innermost first. Alternative and close commands at one level never disturb the saved state of the outer levels.
- R7: A divergent open while `DEPTH` levels are held leaves the mask unchanged and sets `overflow`, which stays set until reset.
- R8: An alternative or close command at top level leaves the mask at all ones and sets `underflow`, which stays set until reset.
- R9: `active_mask` is never all zeros.
- R10: The idle code (`op` = 2'b00) changes nothing, whatever `cond` holds.
- R11: `branch_uniform` and `uniform_taken` are single-cycle pulses. They are high only on the cycle after a uniform open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 2 | Command: 00 idle, 01 open, 10 alternative, 11 close |
| cond | input | LANES | Per-lane condition bits for an open command |
| active_mask | output | LANES | Registered mask of lanes allowed to commit |
| branch_uniform | output | 1 | Pulse: the previous open was uniform |
| uniform_taken | output | 1 | Pulse: the uniform open was taken by all active lanes |
| overflow | output | 1 | Sticky: divergent open with a full stack |
| underflow | output | 1 | Sticky: alternative or close at top level |

## Verification
The bench sweeps every condition vector against the full mask and against a half mask, one level down. This hits both kinds of uniform branch. A design that tested uniformity against all lanes rather than only the active ones would push an empty or unchanged mask there. Every divergent case is followed by an alternative and a close. A design that stored the narrowed mask instead of the condition would produce a wrong alternative mask, and a pop that lost the parent would fail to restore the enclosing mask. The bench also fills the stack to its limit, closes at top level and sends noise on `cond` during idle cycles. These catch a push that overwrites the top entry, a flag that clears itself, and an idle code that disturbs state.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_OPEN  = 2'b01,
        OP_ALT   = 2'b10,
        OP_CLOSE = 2'b11
    } mask_op_e;

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] taken_mask,
    output logic             none_take,
    output logic             all_take
);
    always_comb begin
        taken_mask = cur_mask & cond;
        none_take  = (taken_mask == '0);
        all_take   = (taken_mask == cur_mask);
    end
endmodule

// File: rtl/simt_mask_store.sv
module simt_mask_store #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_parent,
    input  logic [LANES-1:0] wr_cond,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LANES-1:0] rd_parent,
    output logic [LANES-1:0] rd_cond
);
    logic [LANES-1:0] par_q [DEPTH];
    logic [LANES-1:0] cnd_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [LANES-1:0] par_d;
        logic [LANES-1:0] cnd_d;

        always_comb begin
            par_d = par_q[g];
            cnd_d = cnd_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                par_d = wr_parent;
                cnd_d = wr_cond;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                par_q[g] <= '0;
                cnd_q[g] <= '0;
            end else begin
                par_q[g] <= par_d;
                cnd_q[g] <= cnd_d;
            end
        end
    end

    always_comb begin
        rd_parent = par_q[rd_idx];
        rd_cond   = cnd_q[rd_idx];
    end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] active_mask,
    output logic             branch_uniform,
    output logic             uniform_taken,
    output logic             overflow,
    output logic             underflow
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LANES-1:0] cur;
        logic [LVL_W-1:0] lvl;
        logic             uni;
        logic             utaken;
        logic             ovf;
        logic             udf;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [LANES-1:0] taken_mask;
    logic             none_take, all_take;
    logic             push_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [LANES-1:0] rd_parent, rd_cond;
    logic [LVL_W-1:0] depth_now;
    mask_op_e         op_e;

    simt_branch_eval #(.LANES(LANES)) u_eval (
        .cur_mask   (st_q.cur),
        .cond       (cond),
        .taken_mask (taken_mask),
        .none_take  (none_take),
        .all_take   (all_take)
    );

    simt_mask_store #(.LANES(LANES), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (push_en),
        .wr_idx    (wr_idx),
        .wr_parent (st_q.cur),
        .wr_cond   (cond),
        .rd_idx    (rd_idx),
        .rd_parent (rd_parent),
        .rd_cond   (rd_cond)
    );

    always_comb begin
        op_e      = mask_op_e'(op);
        wr_idx    = IDX_W'(st_q.lvl);
        rd_idx    = IDX_W'(st_q.lvl - LVL_W'(1));
        depth_now = st_q.lvl;
    end

    always_comb begin
        st_d        = st_q;
        st_d.uni    = 1'b0;
        st_d.utaken = 1'b0;
        push_en     = 1'b0;
        unique case (op_e)
            OP_OPEN: begin
                if (none_take || all_take) begin
                    st_d.uni    = 1'b1;
                    st_d.utaken = !none_take;
                end else if (st_q.lvl == LVL_W'(DEPTH)) begin
                    st_d.ovf = 1'b1;
                end else begin
                    push_en  = 1'b1;
                    st_d.cur = taken_mask;
                    st_d.lvl = st_q.lvl + LVL_W'(1);
                end
            end
            OP_ALT: begin
                if (st_q.lvl == '0) begin
                    st_d.udf = 1'b1;
                end else begin
                    st_d.cur = rd_parent & ~rd_cond;
                end
            end
            OP_CLOSE: begin
                if (st_q.lvl == '0) begin
                    st_d.udf = 1'b1;
                end else begin
                    st_d.cur = rd_parent;
                    st_d.lvl = st_q.lvl - LVL_W'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cur    <= '1;
            st_q.lvl    <= '0;
            st_q.uni    <= 1'b0;
            st_q.utaken <= 1'b0;
            st_q.ovf    <= 1'b0;
            st_q.udf    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        active_mask    = st_q.cur;
        branch_uniform = st_q.uni;
        uniform_taken  = st_q.utaken;
        overflow       = st_q.ovf;
        underflow      = st_q.udf;
    end
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
    parameter int LANES = 32,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op,
    input logic [LANES-1:0] active_mask,
    input logic             branch_uniform,
    input logic             overflow,
    input logic             underflow,
    input logic [LVL_W-1:0] level
);
    a_r9_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    a_r3_open_narrows: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01) |=> ((active_mask & ~$past(active_mask)) == '0));

    a_r2_uniform_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        branch_uniform |-> (active_mask == $past(active_mask)));

    a_r11_uniform_after_open: assert property (@(posedge clk) disable iff (!rst_n)
        branch_uniform |-> ($past(op) == 2'b01));

    a_r5_close_widens: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b11 && level != '0) |=>
            ((($past(active_mask) & ~active_mask) == '0) && (level == $past(level) - LVL_W'(1))));

    a_r4_alt_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10) |=> $stable(level));

    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .LVL_W(LVL_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op             (op),
    .active_mask    (active_mask),
    .branch_uniform (branch_uniform),
    .overflow       (overflow),
    .underflow      (underflow),
    .level          (depth_now)
);

// File: tb/test_simt_mask_stack.sv
module test_simt_mask_stack;
    localparam int L = 8;
    localparam int D = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [L-1:0] cond = '0;
    logic [L-1:0] active_mask;
    logic         branch_uniform, uniform_taken, overflow, underflow;

    int n_chk = 0;
    int n_fail = 0;

    logic [L-1:0] bm_cur;
    logic [L-1:0] bm_par [D];
    logic [L-1:0] bm_cnd [D];
    int           bm_lvl;
    logic         bm_ovf, bm_udf, bm_uni, bm_ut;

    always #10 clk = ~clk;

    simt_mask_stack #(.LANES(L), .DEPTH(D)) i_simt_mask_stack (
        .clk(clk), .rst_n(rst_n), .op(op), .cond(cond),
        .active_mask(active_mask), .branch_uniform(branch_uniform),
        .uniform_taken(uniform_taken), .overflow(overflow), .underflow(underflow)
    );

    task automatic check(input string tag, input string what, input logic [L-1:0] act, input logic [L-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "mask", active_mask, bm_cur);
        check(tag, "uniform", L'(branch_uniform), L'(bm_uni));
        check(tag, "taken", L'(uniform_taken), L'(bm_ut));
        check(tag, "overflow", L'(overflow), L'(bm_ovf));
        check(tag, "underflow", L'(underflow), L'(bm_udf));
        check("R9", "nonzero", L'(active_mask != '0), L'(1));
    endtask

    task automatic model_reset();
        bm_cur = '1; bm_lvl = 0; bm_ovf = 0; bm_udf = 0; bm_uni = 0; bm_ut = 0;
        for (int i = 0; i < D; i++) begin bm_par[i] = '0; bm_cnd[i] = '0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op = 2'b00; cond = '0;
        model_reset();
        repeat (2) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
    endtask

    task automatic apply(input logic [1:0] o, input logic [L-1:0] c, input string tag);
        logic [L-1:0] t;
        bm_uni = 0; bm_ut = 0;
        case (o)
            2'b01: begin
                t = bm_cur & c;
                if (t == '0 || t == bm_cur) begin
                    bm_uni = 1; bm_ut = (t != '0);
                end else if (bm_lvl == D) begin
                    bm_ovf = 1;
                end else begin
                    bm_par[bm_lvl] = bm_cur; bm_cnd[bm_lvl] = c;
                    bm_lvl++; bm_cur = t;
                end
            end
            2'b10: if (bm_lvl == 0) bm_udf = 1;
                   else bm_cur = bm_par[bm_lvl-1] & ~bm_cnd[bm_lvl-1];
            2'b11: if (bm_lvl == 0) bm_udf = 1;
                   else begin bm_lvl--; bm_cur = bm_par[bm_lvl]; end
            default: ;
        endcase
        @(negedge clk);
        op = o; cond = c;
        @(negedge clk);
        op = 2'b00; cond = '0;
        check_all(tag);
    endtask

    function automatic string open_tag(input logic [L-1:0] m, input logic [L-1:0] c);
        return (((m & c) == '0) || ((m & c) == m)) ? "R2" : "R3";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R2 R3 R4 R5: every condition against the full mask
        for (int c = 0; c < 256; c++) begin
            string tg;
            tg = open_tag(bm_cur, L'(c));
            apply(2'b01, L'(c), tg);
            if (tg == "R3") begin
                apply(2'b10, ~L'(c), "R4");
                apply(2'b11, L'(c), "R5");
            end
            apply(2'b00, L'(c), "R11");
        end

        // one level down: uniformity judged over active lanes only
        apply(2'b01, 8'h0F, "R3");
        for (int c = 0; c < 256; c++) begin
            string tg;
            tg = open_tag(bm_cur, L'(c));
            apply(2'b01, L'(c), tg);
            if (tg == "R3") begin
                apply(2'b10, 8'h00, "R4");
                apply(2'b11, 8'h00, "R5");
            end
        end
        apply(2'b11, 8'h00, "R5");

        // R6: nested unwinding
        apply(2'b01, 8'h03, "R6");
        apply(2'b01, 8'h01, "R6");
        check("R6", "inner", active_mask, 8'h01);
        apply(2'b10, 8'hAA, "R6");
        check("R6", "inner alt", active_mask, 8'h02);
        apply(2'b11, 8'h00, "R6");
        check("R6", "outer back", active_mask, 8'h03);
        apply(2'b10, 8'h00, "R6");
        check("R6", "outer alt", active_mask, 8'hFC);
        apply(2'b11, 8'h00, "R6");
        check("R6", "top", active_mask, 8'hFF);

        // R10: idle with noise on cond
        apply(2'b01, 8'h3C, "R3");
        for (int c = 0; c < 8; c++) apply(2'b00, L'(c * 37), "R10");
        apply(2'b11, 8'h00, "R5");

        // R7: fill the stack, then overflow
        apply(2'b01, 8'h7F, "R3");
        apply(2'b01, 8'h3F, "R3");
        apply(2'b01, 8'h1F, "R3");
        apply(2'b01, 8'h0F, "R7");
        check("R7", "mask kept", active_mask, 8'h1F);
        apply(2'b01, 8'hFF, "R2");
        apply(2'b10, 8'h00, "R4");
        apply(2'b11, 8'h00, "R5");
        apply(2'b11, 8'h00, "R5");
        apply(2'b11, 8'h00, "R5");
        check("R7", "sticky", L'(overflow), L'(1));

        // R8: top-level alternative and close
        apply(2'b11, 8'h00, "R8");
        apply(2'b10, 8'h55, "R8");
        apply(2'b00, 8'h00, "R8");

        do_reset();
        apply(2'b10, 8'h00, "R8");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule